// File: doc/BRIEF.md
# Counted-Loop Stage Predicate Controller

This block carries out the closing branch of a software-pipelined loop whose trip count is known before the loop starts. It keeps two down-counters. The trip counter holds how many more iterations remain to be started. The drain counter holds how many pipeline stages must still run once no new iterations are started. Before the loop begins, software loads both counters through a setup port.

Each time the loop branch executes, the controller reports three things: whether the branch is taken, what value to write into the first-stage rotating predicate, and whether the register base should rotate. While iterations remain, each branch starts a new iteration with a true predicate. After that, each branch pushes a false predicate so the pipeline drains stage by stage. The last drain step falls through and leaves the loop.

A busy flag tells the surrounding control whether any loop work is pending. Decision outputs are combinational on the branch strobe by default. A parameter can add one register stage on them instead.

Top module: `loop_pred_ctrl`

## Requirements
- R1: After reset both counters are zero, `busy` is low, and `br_taken`, `stage_pred` and `base_rot` are low.
- R2: A branch with a nonzero trip count is taken, writes predicate 1, asserts `base_rot`, and lowers the trip count by one.
- R3: A branch with a zero trip count and a drain count above 1 is taken, writes predicate 0, asserts `base_rot`, and lowers the drain count by one.
- R4: A branch with a zero trip count and a drain count of exactly 1 falls through: `br_taken` and `base_rot` are low, the predicate is 0, and the drain count becomes 0.
- R5: A branch with both counters at zero leaves every output low, and neither counter wraps below zero.
- R6: While the trip count is nonzero, a branch leaves the drain count unchanged.
- R7: A setup load in the same cycle as a branch wins. The branch is ignored: all three decision outputs are low, the loaded counter takes the load value, and the other counter keeps its value.
- R8: `busy` is high exactly when either counter is nonzero.
- R9: In a cycle without a branch, all decision outputs are low and both counters hold their values.
- R10: Starting from a trip count N and a drain count E ≥ 1, the loop branch is taken N+E−1 times in a row and falls through on branch N+E. The first N taken branches write predicate 1 and the rest write 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_ld | input | 1 | Load the trip counter |
| trip_val | input | LC_W | Trip count to load |
| drain_ld | input | 1 | Load the drain counter |
| drain_val | input | EC_W | Drain count to load |
| br_exec | input | 1 | Loop branch executes this cycle |
| br_taken | output | 1 | Branch goes back to the loop top |
| stage_pred | output | 1 | Value written to the first-stage predicate |
| base_rot | output | 1 | Request to decrement the register base |
| busy | output | 1 | A counter is nonzero |

## Verification
The bench sweeps every pair of trip and drain counts in a small configuration, with and without idle cycles between branches. At each branch it compares the outputs against the closed-form sequence. This catches an early or late fall-through, a rotation on the exit branch, and a drain counter that moves while iterations remain. The case with both counters at zero would show a wrapping counter as a stuck `busy`. A drain count of zero with a nonzero trip count must still exit cleanly with no false-predicate steps. Loads that collide with a branch are checked as well: a design that let the branch through would emit a taken strobe or end the loop one iteration short.

// File: rtl/loop_pred_pkg.sv
package loop_pred_pkg;

   // Decision produced for one loop-branch execution
   typedef struct packed {
      logic taken;
      logic pred;
      logic rot;
   } lp_act_t;

   localparam lp_act_t LP_ACT_IDLE = '{taken: 1'b0, pred: 1'b0, rot: 1'b0};

endpackage

// File: rtl/lp_downcnt.sv
module lp_downcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt
);

   if (W < 1 || W > 32) begin : g_bad_w
      $error("lp_downcnt: W out of range");
   end

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (dec && cnt != '0)  cnt <= cnt - ONE;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> cnt == '0); // R5

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val)); // R7

endmodule

// File: rtl/lp_decide.sv
module lp_decide
   import loop_pred_pkg::*;
#(
   parameter int LC_W = 8,
   parameter int EC_W = 4
) (
   input  logic            br_go,
   input  logic [LC_W-1:0] lc,
   input  logic [EC_W-1:0] ec,
   output lp_act_t         act,
   output logic            lc_dec,
   output logic            ec_dec
);

   localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

   logic lc_nz, ec_nz, ec_more;

   always_comb begin
      lc_nz   = (lc != '0);
      ec_nz   = (ec != '0);
      ec_more = (ec > EC_ONE);
      act       = LP_ACT_IDLE;
      act.taken = br_go & (lc_nz | ec_more);
      act.pred  = br_go & lc_nz;
      act.rot   = br_go & (lc_nz | ec_more);
      lc_dec    = br_go & lc_nz;
      ec_dec    = br_go & ~lc_nz & ec_nz;
   end

endmodule

// File: rtl/loop_pred_ctrl.sv
module loop_pred_ctrl
   import loop_pred_pkg::*;
#(
   parameter int LC_W    = 8,
   parameter int EC_W    = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trip_ld,
   input  logic [LC_W-1:0] trip_val,
   input  logic            drain_ld,
   input  logic [EC_W-1:0] drain_val,
   input  logic            br_exec,
   output logic            br_taken,
   output logic            stage_pred,
   output logic            base_rot,
   output logic            busy
);

   if (LC_W < 1 || LC_W > 32) begin : g_bad_lc
      $error("loop_pred_ctrl: LC_W out of range");
   end
   if (EC_W < 1 || EC_W > 32) begin : g_bad_ec
      $error("loop_pred_ctrl: EC_W out of range");
   end

   logic [LC_W-1:0] lc_q;
   logic [EC_W-1:0] ec_q;
   logic            br_go, lc_dec, ec_dec;
   lp_act_t         act;

   assign br_go = br_exec & ~trip_ld & ~drain_ld;

   lp_downcnt #(.W(LC_W)) u_trip (
      .clk(clk), .rst_n(rst_n), .load(trip_ld), .load_val(trip_val),
      .dec(lc_dec), .cnt(lc_q)
   );

   lp_downcnt #(.W(EC_W)) u_drain (
      .clk(clk), .rst_n(rst_n), .load(drain_ld), .load_val(drain_val),
      .dec(ec_dec), .cnt(ec_q)
   );

   lp_decide #(.LC_W(LC_W), .EC_W(EC_W)) u_decide (
      .br_go(br_go), .lc(lc_q), .ec(ec_q),
      .act(act), .lc_dec(lc_dec), .ec_dec(ec_dec)
   );

   assign busy = (lc_q != '0) | (ec_q != '0);

   if (OUT_REG) begin : g_out_reg
      lp_act_t act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= LP_ACT_IDLE;
         else        act_q <= act;
      end
      assign br_taken   = act_q.taken;
      assign stage_pred = act_q.pred;
      assign base_rot   = act_q.rot;
   end else begin : g_out_comb
      assign br_taken   = act.taken;
      assign stage_pred = act.pred;
      assign base_rot   = act.rot;

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !br_exec |-> !br_taken && !stage_pred && !base_rot); // R9

      AST_EXIT_NO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
         (br_go && lc_q == '0 && ec_q <= EC_W'(1)) |-> !br_taken && !base_rot); // R4

      AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         (trip_ld || drain_ld) |-> !br_taken && !base_rot && !stage_pred); // R7
   end

   AST_TRIP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (br_go && lc_q != '0) |=> lc_q == $past(lc_q) - LC_W'(1)); // R2

   AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (br_go && lc_q != '0) |=> ec_q == $past(ec_q)); // R6

   AST_DRAIN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (br_go && lc_q == '0 && ec_q != '0) |=> ec_q == $past(ec_q) - EC_W'(1)); // R3

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_exec && !trip_ld && !drain_ld) |=> $stable(lc_q) && $stable(ec_q)); // R9

endmodule

// File: tb/loop_pred_ctrl_tb.sv
module loop_pred_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int LC_W = 3;
   localparam int EC_W = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            trip_ld = 1'b0;
   logic [LC_W-1:0] trip_val = '0;
   logic            drain_ld = 1'b0;
   logic [EC_W-1:0] drain_val = '0;
   logic            br_exec = 1'b0;
   logic            br_taken, stage_pred, base_rot, busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   loop_pred_ctrl #(.LC_W(LC_W), .EC_W(EC_W), .OUT_REG(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .trip_ld(trip_ld), .trip_val(trip_val),
      .drain_ld(drain_ld), .drain_val(drain_val),
      .br_exec(br_exec),
      .br_taken(br_taken), .stage_pred(stage_pred), .base_rot(base_rot),
      .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int pack3(input logic t, input logic p, input logic r);
      return {29'd0, t, p, r};
   endfunction

   // Load counters with no branch; busy checked after the edge (R8)
   task automatic load_both(input int n, input int e);
      @(negedge clk);
      trip_ld = 1'b1; trip_val = LC_W'(n);
      drain_ld = 1'b1; drain_val = EC_W'(e);
      #1 chk(pack3(br_taken, stage_pred, base_rot) == 0, "R9", pack3(br_taken, stage_pred, base_rot), 0);
      @(posedge clk); #1;
      trip_ld = 1'b0; drain_ld = 1'b0;
      chk(busy == ((n != 0) || (e != 0)), "R8", busy, int'((n != 0) || (e != 0)));
   endtask

   // Issue branches for a loaded (n,e) pair and compare with closed form (R2,R3,R4,R10)
   task automatic run_seq(input int n, input int e, input bit gaps);
      for (int k = 0; k <= n + e; k++) begin
         int exp_o;
         int exp_b;
         string req;
         if (k < n) begin
            exp_o = pack3(1, 1, 1); req = "R2/R10";
         end else if (k < n + e - 1) begin
            exp_o = pack3(1, 0, 1); req = "R3/R10";
         end else if (k == n + e - 1 && e >= 1) begin
            exp_o = 0; req = "R4/R10";
         end else begin
            exp_o = 0; req = "R5";
         end
         exp_b = (k + 1 < n + e) ? 1 : 0;
         @(negedge clk);
         br_exec = 1'b1;
         #1 chk(pack3(br_taken, stage_pred, base_rot) == exp_o, req,
                pack3(br_taken, stage_pred, base_rot), exp_o);
         @(posedge clk); #1;
         br_exec = 1'b0;
         chk(busy == exp_b[0], "R8/R6", busy, exp_b);
         if (gaps) begin
            @(negedge clk);
            #1 chk(pack3(br_taken, stage_pred, base_rot) == 0, "R9",
                   pack3(br_taken, stage_pred, base_rot), 0);
            @(posedge clk); #1;
            chk(busy == exp_b[0], "R9", busy, exp_b);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy == 1'b0, "R1", busy, 0);
      chk(pack3(br_taken, stage_pred, base_rot) == 0, "R1", pack3(br_taken, stage_pred, base_rot), 0);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk(busy == 1'b0, "R1", busy, 0);

      // R5: branch with both counters zero
      run_seq(0, 0, 1'b0);

      // Full sweep of the small configuration (R2, R3, R4, R6, R10)
      for (int n = 0; n < (1 << LC_W); n++) begin
         for (int e = 0; e < (1 << EC_W); e++) begin
            load_both(n, e);
            run_seq(n, e, ((n + e) % 2) == 1);
         end
      end

      // R7: trip load collides with a branch mid-loop
      load_both(5, 2);
      run_seq_partial(2);
      @(negedge clk);
      br_exec = 1'b1; trip_ld = 1'b1; trip_val = LC_W'(6);
      #1 chk(pack3(br_taken, stage_pred, base_rot) == 0, "R7",
             pack3(br_taken, stage_pred, base_rot), 0);
      @(posedge clk); #1;
      br_exec = 1'b0; trip_ld = 1'b0;
      run_seq(6, 2, 1'b0);

      // R7: drain load collides with a branch in the drain phase
      load_both(0, 4);
      @(negedge clk);
      br_exec = 1'b1; drain_ld = 1'b1; drain_val = EC_W'(2);
      #1 chk(pack3(br_taken, stage_pred, base_rot) == 0, "R7",
             pack3(br_taken, stage_pred, base_rot), 0);
      @(posedge clk); #1;
      br_exec = 1'b0; drain_ld = 1'b0;
      run_seq(0, 2, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // Issue a few trip-phase branches (R2)
   task automatic run_seq_partial(input int cnt);
      for (int k = 0; k < cnt; k++) begin
         @(negedge clk);
         br_exec = 1'b1;
         #1 chk(pack3(br_taken, stage_pred, base_rot) == pack3(1, 1, 1), "R2",
                pack3(br_taken, stage_pred, base_rot), 7);
         @(posedge clk); #1;
         br_exec = 1'b0;
      end
   endtask

endmodule